// File: doc/BRIEF.md
# RV32E Instruction Decoder

This block turns one 32-bit instruction word into the control fields that the rest of a small 16-register integer core needs. From the word it derives a one-hot major class, the three register indices, an ALU operation select that includes the two conditional-zero operations, an immediate-format select, and a single illegal-instruction flag. It has no clock and no state: all outputs follow the input word in the same cycle.

The decoder is placed between instruction fetch and the register file. Forming the immediate value, reading registers and running the ALU happen elsewhere. The illegal flag combines every reason to reject a word: a wrong low-bit pattern, an unmapped major opcode, an undefined function-field combination, or a used register field that names a register above x15.

Top module: `rv32e_decoder`

## Requirements
- R1: When instr_i[1:0] is not 2'b11, illegal_o is 1 and cls_o is all zero.
- R2: With instr_i[1:0] = 2'b11, the major opcode instr_i[6:2] sets exactly one cls_o bit: 00000 bit0 LOAD, 01000 bit1 STORE, 01100 bit2 OP, 00100 bit3 OP-IMM, 01101 bit4 LUI, 00101 bit5 AUIPC, 11011 bit6 JAL, 11001 bit7 JALR, 11000 bit8 BRANCH, 00011 bit9 MISC-MEM, 11100 bit10 SYSTEM. Any other major opcode gives cls_o = 0 and illegal_o = 1.
- R3: rd_o = instr_i[10:7], rs1_o = instr_i[18:15] and rs2_o = instr_i[23:20] for every word.
- R4: illegal_o is 1 when a register field the class uses has its top bit set (rd bit instr_i[11], rs1 bit instr_i[19], rs2 bit instr_i[24]). rd is used by LOAD, OP, OP-IMM, LUI, AUIPC, JAL, JALR; rs1 by LOAD, STORE, OP, OP-IMM, JALR, BRANCH; rs2 by STORE, OP, BRANCH. Bits of fields a class does not use have no effect on illegal_o.
- R5: alu_op_o codes are ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9, CZERO_EQZ=10, CZERO_NEZ=11. In OP with funct7 (instr_i[31:25]) = 0000000, funct3 (instr_i[14:12]) 000..111 selects ADD, SLL, SLT, SLTU, XOR, SRL, OR, AND; with funct7 = 0100000, funct3 000 gives SUB and 101 gives SRA.
- R6: In OP, funct7 = 0000111 with funct3 = 101 selects CZERO_EQZ and with funct3 = 111 selects CZERO_NEZ.
- R7: In OP-IMM, funct3 000, 010, 011, 100, 110, 111 select ADD, SLT, SLTU, XOR, OR, AND; funct3 001 selects SLL and funct3 101 selects SRL when instr_i[31:25] = 0000000 and SRA when it is 0100000.
- R8: In OP, any funct7/funct3 pair not listed in R5 or R6 is illegal; in OP-IMM, funct3 001 with instr_i[31:25] other than 0000000, and funct3 101 with instr_i[31:25] other than 0000000 or 0100000, are illegal.
- R9: LOAD with funct3 011, 110 or 111, STORE with funct3 011 or above, and BRANCH with funct3 010 or 011 are illegal.
- R10: imm_fmt_o codes are NONE=0, I=1, S=2, B=3, U=4, J=5: I for LOAD, OP-IMM, JALR; S for STORE; B for BRANCH; U for LUI, AUIPC; J for JAL; NONE for OP, MISC-MEM, SYSTEM and whenever cls_o is zero.
- R11: For a legal word of any class other than OP and OP-IMM, alu_op_o is ADD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| cls_o | output | 11 | One-hot major class, zero when the major opcode is not recognised |
| rd_o | output | 4 | Destination register index |
| rs1_o | output | 4 | First source register index |
| rs2_o | output | 4 | Second source register index |
| alu_op_o | output | 4 | ALU operation select |
| imm_fmt_o | output | 3 | Immediate-format select |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
Every output is due in the same cycle as the word that produces it, with no register in any path, so each result is due zero cycles after the stimulus. The bench applies a new word on the falling clock edge and samples all outputs one nanosecond later, once the combinational logic has settled and well before the next rising edge. The ALU select is compared only for words the reference model deems legal, while class, format, register indices and the illegal flag are compared for every word, including words with bad low bits, unmapped opcodes and out-of-range register fields.

// File: rtl/rv32e_dec_pkg.sv
// Shared constants and types for the RV32E instruction decoder.
// Assumes a 32-bit instruction word with the standard field layout.
package rv32e_dec_pkg;

    localparam int INSN_W     = 32;
    localparam int FIELD_W    = 5;
    localparam int NUM_REGS   = 16;
    localparam int REG_IDX_W  = $clog2(NUM_REGS);
    localparam int NUM_CLASS  = 11;
    localparam int NUM_RFIELD = 3;

    // Bit position of each major class in the one-hot vector
    typedef enum logic [3:0] {
        CLS_LOAD     = 4'd0,
        CLS_STORE    = 4'd1,
        CLS_OP       = 4'd2,
        CLS_OP_IMM   = 4'd3,
        CLS_LUI      = 4'd4,
        CLS_AUIPC    = 4'd5,
        CLS_JAL      = 4'd6,
        CLS_JALR     = 4'd7,
        CLS_BRANCH   = 4'd8,
        CLS_MISC_MEM = 4'd9,
        CLS_SYSTEM   = 4'd10
    } cls_idx_e;

    typedef enum logic [3:0] {
        ALU_ADD   = 4'd0,
        ALU_SUB   = 4'd1,
        ALU_SLL   = 4'd2,
        ALU_SLT   = 4'd3,
        ALU_SLTU  = 4'd4,
        ALU_XOR   = 4'd5,
        ALU_SRL   = 4'd6,
        ALU_SRA   = 4'd7,
        ALU_OR    = 4'd8,
        ALU_AND   = 4'd9,
        ALU_CZEQZ = 4'd10,
        ALU_CZNEZ = 4'd11
    } alu_op_e;

    typedef enum logic [2:0] {
        IMM_NONE = 3'd0,
        IMM_I    = 3'd1,
        IMM_S    = 3'd2,
        IMM_B    = 3'd3,
        IMM_U    = 3'd4,
        IMM_J    = 3'd5
    } imm_fmt_e;

    // Major opcode values taken from instruction bits [6:2]
    localparam logic [4:0] OPC_LOAD     = 5'b00000;
    localparam logic [4:0] OPC_MISC_MEM = 5'b00011;
    localparam logic [4:0] OPC_OP_IMM   = 5'b00100;
    localparam logic [4:0] OPC_AUIPC    = 5'b00101;
    localparam logic [4:0] OPC_STORE    = 5'b01000;
    localparam logic [4:0] OPC_OP       = 5'b01100;
    localparam logic [4:0] OPC_LUI      = 5'b01101;
    localparam logic [4:0] OPC_BRANCH   = 5'b11000;
    localparam logic [4:0] OPC_JALR     = 5'b11001;
    localparam logic [4:0] OPC_JAL      = 5'b11011;
    localparam logic [4:0] OPC_SYSTEM   = 5'b11100;

    localparam logic [6:0] F7_BASE  = 7'b0000000;
    localparam logic [6:0] F7_ALT   = 7'b0100000;
    localparam logic [6:0] F7_CZERO = 7'b0000111;

    // Which register fields a class reads or writes
    typedef struct packed {
        logic rs2;
        logic rs1;
        logic rd;
    } reg_use_t;

endpackage

// File: rtl/rv32e_major_dec.sv
// Major-class decoder: maps the low two bits and the major opcode to a
// one-hot class, the immediate format and the register fields in use.
// Assumes nothing about the function fields; those are handled elsewhere.
module rv32e_major_dec
    import rv32e_dec_pkg::*;
#(
    parameter int N_CLASS = NUM_CLASS
) (
    input  logic [1:0]         quad_i,
    input  logic [4:0]         opc_i,
    output logic [N_CLASS-1:0] cls_o,
    output logic               known_o,
    output imm_fmt_e           fmt_o,
    output reg_use_t           use_o
);

    // Table lookup of class, format and field use from the opcode
    always_comb begin
        cls_o = '0;
        fmt_o = IMM_NONE;
        use_o = '{rs2: 1'b0, rs1: 1'b0, rd: 1'b0};
        if (quad_i == 2'b11) begin
            case (opc_i)
                OPC_LOAD: begin
                    cls_o[CLS_LOAD] = 1'b1;
                    fmt_o = IMM_I;
                    use_o = '{rs2: 1'b0, rs1: 1'b1, rd: 1'b1};
                end
                OPC_STORE: begin
                    cls_o[CLS_STORE] = 1'b1;
                    fmt_o = IMM_S;
                    use_o = '{rs2: 1'b1, rs1: 1'b1, rd: 1'b0};
                end
                OPC_OP: begin
                    cls_o[CLS_OP] = 1'b1;
                    use_o = '{rs2: 1'b1, rs1: 1'b1, rd: 1'b1};
                end
                OPC_OP_IMM: begin
                    cls_o[CLS_OP_IMM] = 1'b1;
                    fmt_o = IMM_I;
                    use_o = '{rs2: 1'b0, rs1: 1'b1, rd: 1'b1};
                end
                OPC_LUI: begin
                    cls_o[CLS_LUI] = 1'b1;
                    fmt_o = IMM_U;
                    use_o = '{rs2: 1'b0, rs1: 1'b0, rd: 1'b1};
                end
                OPC_AUIPC: begin
                    cls_o[CLS_AUIPC] = 1'b1;
                    fmt_o = IMM_U;
                    use_o = '{rs2: 1'b0, rs1: 1'b0, rd: 1'b1};
                end
                OPC_JAL: begin
                    cls_o[CLS_JAL] = 1'b1;
                    fmt_o = IMM_J;
                    use_o = '{rs2: 1'b0, rs1: 1'b0, rd: 1'b1};
                end
                OPC_JALR: begin
                    cls_o[CLS_JALR] = 1'b1;
                    fmt_o = IMM_I;
                    use_o = '{rs2: 1'b0, rs1: 1'b1, rd: 1'b1};
                end
                OPC_BRANCH: begin
                    cls_o[CLS_BRANCH] = 1'b1;
                    fmt_o = IMM_B;
                    use_o = '{rs2: 1'b1, rs1: 1'b1, rd: 1'b0};
                end
                OPC_MISC_MEM: cls_o[CLS_MISC_MEM] = 1'b1;
                OPC_SYSTEM:   cls_o[CLS_SYSTEM]   = 1'b1;
                default: ;
            endcase
        end
    end

    // A word is recognised when any class bit is set
    assign known_o = |cls_o;

endmodule

// File: rtl/rv32e_func_dec.sv
// Function-field decoder: picks the ALU operation for OP and OP-IMM and
// flags undefined funct3/funct7 patterns for every class that has them.
// Assumes the class vector is one-hot or zero.
module rv32e_func_dec
    import rv32e_dec_pkg::*;
#(
    parameter int N_CLASS = NUM_CLASS
) (
    input  logic [N_CLASS-1:0] cls_i,
    input  logic [2:0]         f3_i,
    input  logic [6:0]         f7_i,
    output alu_op_e            alu_o,
    output logic               bad_o
);

    // Base-form operation for a funct3 value shared by OP and OP-IMM
    function automatic alu_op_e base_op(input logic [2:0] f3);
        case (f3)
            3'b000:  base_op = ALU_ADD;
            3'b001:  base_op = ALU_SLL;
            3'b010:  base_op = ALU_SLT;
            3'b011:  base_op = ALU_SLTU;
            3'b100:  base_op = ALU_XOR;
            3'b101:  base_op = ALU_SRL;
            3'b110:  base_op = ALU_OR;
            default: base_op = ALU_AND;
        endcase
    endfunction

    // Operation select and legality of the function fields per class
    always_comb begin
        alu_o = ALU_ADD;
        bad_o = 1'b0;
        if (cls_i[CLS_OP]) begin
            case (f7_i)
                F7_BASE: alu_o = base_op(f3_i);
                F7_ALT: begin
                    if (f3_i == 3'b000)      alu_o = ALU_SUB;
                    else if (f3_i == 3'b101) alu_o = ALU_SRA;
                    else                     bad_o = 1'b1;
                end
                F7_CZERO: begin
                    if (f3_i == 3'b101)      alu_o = ALU_CZEQZ;
                    else if (f3_i == 3'b111) alu_o = ALU_CZNEZ;
                    else                     bad_o = 1'b1;
                end
                default: bad_o = 1'b1;
            endcase
        end else if (cls_i[CLS_OP_IMM]) begin
            case (f3_i)
                3'b001: begin
                    alu_o = ALU_SLL;
                    bad_o = (f7_i != F7_BASE);
                end
                3'b101: begin
                    if (f7_i == F7_BASE)     alu_o = ALU_SRL;
                    else if (f7_i == F7_ALT) alu_o = ALU_SRA;
                    else                     bad_o = 1'b1;
                end
                default: alu_o = base_op(f3_i);
            endcase
        end else if (cls_i[CLS_LOAD]) begin
            bad_o = (f3_i == 3'b011) || (f3_i[2:1] == 2'b11);
        end else if (cls_i[CLS_STORE]) begin
            bad_o = (f3_i >= 3'b011);
        end else if (cls_i[CLS_BRANCH]) begin
            bad_o = (f3_i[2:1] == 2'b01);
        end
    end

endmodule

// File: rtl/rv32e_reg_chk.sv
// Register-field checker: cuts each 5-bit field to the index width of the
// reduced register file and flags any used field that names a register
// beyond it. Assumes FIELD_W is larger than IDX_W.
module rv32e_reg_chk #(
    parameter int FIELD_W = 5,
    parameter int IDX_W   = 4,
    parameter int N_FIELD = 3
) (
    input  logic [N_FIELD*FIELD_W-1:0] fields_i,
    input  logic [N_FIELD-1:0]         used_i,
    output logic [N_FIELD*IDX_W-1:0]   idx_o,
    output logic                       bad_o
);

    localparam int HI_W = FIELD_W - IDX_W;

    logic [N_FIELD-1:0] hi_bad;

    // One slice per field: low bits become the index, high bits the range check
    for (genvar g = 0; g < N_FIELD; g++) begin : g_field
        assign idx_o[g*IDX_W +: IDX_W] = fields_i[g*FIELD_W +: IDX_W];
        assign hi_bad[g] = used_i[g] & (|fields_i[g*FIELD_W+IDX_W +: HI_W]);
    end

    // Any out-of-range used field rejects the word
    assign bad_o = |hi_bad;

endmodule

// File: rtl/rv32e_decoder.sv
// RV32E instruction decoder top: combines the major-class, function-field
// and register-field decoders into one combinational stage.
// Assumes a 32-bit word is presented whole; no state is held.
module rv32e_decoder
    import rv32e_dec_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic [INSN_W-1:0]    instr_i,
    output logic [NUM_CLASS-1:0] cls_o,
    output logic [$clog2(N_REGS)-1:0] rd_o,
    output logic [$clog2(N_REGS)-1:0] rs1_o,
    output logic [$clog2(N_REGS)-1:0] rs2_o,
    output logic [3:0]           alu_op_o,
    output logic [2:0]           imm_fmt_o,
    output logic                 illegal_o
);

    localparam int IDX_W = $clog2(N_REGS);

    logic                          known;
    imm_fmt_e                      fmt;
    reg_use_t                      use_w;
    alu_op_e                       alu;
    logic                          func_bad;
    logic                          reg_bad;
    logic [NUM_RFIELD*IDX_W-1:0]   idx_all;

    rv32e_major_dec #(
        .N_CLASS (NUM_CLASS)
    ) u_major (
        .quad_i  (instr_i[1:0]),
        .opc_i   (instr_i[6:2]),
        .cls_o   (cls_o),
        .known_o (known),
        .fmt_o   (fmt),
        .use_o   (use_w)
    );

    rv32e_func_dec #(
        .N_CLASS (NUM_CLASS)
    ) u_func (
        .cls_i (cls_o),
        .f3_i  (instr_i[14:12]),
        .f7_i  (instr_i[31:25]),
        .alu_o (alu),
        .bad_o (func_bad)
    );

    rv32e_reg_chk #(
        .FIELD_W (FIELD_W),
        .IDX_W   (IDX_W),
        .N_FIELD (NUM_RFIELD)
    ) u_regs (
        .fields_i ({instr_i[24:20], instr_i[19:15], instr_i[11:7]}),
        .used_i   ({use_w.rs2, use_w.rs1, use_w.rd}),
        .idx_o    (idx_all),
        .bad_o    (reg_bad)
    );

    // Split the packed indices back into the three register outputs
    assign rd_o  = idx_all[0*IDX_W +: IDX_W];
    assign rs1_o = idx_all[1*IDX_W +: IDX_W];
    assign rs2_o = idx_all[2*IDX_W +: IDX_W];

    // Drive the selects and merge every rejection reason
    assign alu_op_o  = alu;
    assign imm_fmt_o = fmt;
    assign illegal_o = ~known | func_bad | reg_bad;

endmodule

// File: rtl/rv32e_decoder_chk.sv
// Assertion checker for the RV32E decoder, bound to the top module.
// Assumes outputs settle combinationally from instr_i.
module rv32e_decoder_chk
    import rv32e_dec_pkg::*;
(
    input logic [31:0] instr_i,
    input logic [10:0] cls_o,
    input logic [3:0]  alu_op_o,
    input logic [2:0]  imm_fmt_o,
    input logic        illegal_o
);

    localparam logic [10:0] RD_CLASSES = 11'b00011111101;
    localparam logic [10:0] ARITH_CLASSES = 11'b00000001100;

    // Check output relations whenever the word or outputs change
    always_comb begin
        // R2
        cls_onehot_chk: assert ($onehot0(cls_o));
        // R1
        if (instr_i[1:0] != 2'b11)
            quad_illegal_chk: assert (illegal_o && cls_o == '0);
        // R2
        if (cls_o == '0)
            nocls_illegal_chk: assert (illegal_o);
        // R4
        if (!illegal_o && (cls_o & RD_CLASSES) != '0)
            rd_range_chk: assert (!instr_i[11]);
        // R6
        if (alu_op_o == 4'(ALU_CZEQZ) || alu_op_o == 4'(ALU_CZNEZ))
            czero_cls_chk: assert (cls_o[CLS_OP]);
        // R10
        if (imm_fmt_o != 3'(IMM_NONE))
            fmt_cls_chk: assert (cls_o != '0);
        // R11
        if (!illegal_o && (cls_o & ARITH_CLASSES) == '0)
            other_add_chk: assert (alu_op_o == 4'(ALU_ADD));
    end

endmodule

bind rv32e_decoder rv32e_decoder_chk u_chk (
    .instr_i   (instr_i),
    .cls_o     (cls_o),
    .alu_op_o  (alu_op_o),
    .imm_fmt_o (imm_fmt_o),
    .illegal_o (illegal_o)
);

// File: tb/rv32e_decoder_tb.sv
`timescale 1ns/1ps
module rv32e_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [10:0] cls;
    logic [3:0]  rd, rs1, rs2, alu;
    logic [2:0]  fmt;
    logic        ill;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rv32e_decoder u_dut (
        .instr_i   (instr),
        .cls_o     (cls),
        .rd_o      (rd),
        .rs1_o     (rs1),
        .rs2_o     (rs2),
        .alu_op_o  (alu),
        .imm_fmt_o (fmt),
        .illegal_o (ill)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2,
                                        input logic [4:0] r1, input logic [2:0] f3,
                                        input logic [4:0] d, input logic [4:0] opc);
        return {f7, r2, r1, f3, d, opc, 2'b11};
    endfunction

    function automatic logic [3:0] tbl(input logic [2:0] f3);
        logic [3:0] m [8] = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9};
        return m[f3];
    endfunction

    // Reference model: {illegal, fmt, alu, cls}
    function automatic logic [18:0] model(input logic [31:0] w);
        logic [10:0] c = '0;
        logic [2:0]  f = 3'd0;
        logic [3:0]  a = 4'd0;
        logic        b = 1'b0;
        logic        ud = 0, u1 = 0, u2 = 0;
        logic [2:0]  f3 = w[14:12];
        logic [6:0]  f7 = w[31:25];
        if (w[1:0] != 2'b11) b = 1'b1;
        else begin
            case (w[6:2])
                5'b00000: begin c[0] = 1; f = 1; ud = 1; u1 = 1;
                                b = (f3 == 3) || (f3 == 6) || (f3 == 7); end
                5'b01000: begin c[1] = 1; f = 2; u1 = 1; u2 = 1; b = (f3 > 2); end
                5'b01100: begin c[2] = 1; ud = 1; u1 = 1; u2 = 1;
                    if (f7 == 0) a = tbl(f3);
                    else if (f7 == 7'd32 && f3 == 0) a = 1;
                    else if (f7 == 7'd32 && f3 == 5) a = 7;
                    else if (f7 == 7'd7 && f3 == 5) a = 10;
                    else if (f7 == 7'd7 && f3 == 7) a = 11;
                    else b = 1;
                end
                5'b00100: begin c[3] = 1; f = 1; ud = 1; u1 = 1;
                    if (f3 == 1) begin a = 2; b = (f7 != 0); end
                    else if (f3 == 5) begin
                        if (f7 == 0) a = 6; else if (f7 == 7'd32) a = 7; else b = 1;
                    end else a = tbl(f3);
                end
                5'b01101: begin c[4] = 1; f = 4; ud = 1; end
                5'b00101: begin c[5] = 1; f = 4; ud = 1; end
                5'b11011: begin c[6] = 1; f = 5; ud = 1; end
                5'b11001: begin c[7] = 1; f = 1; ud = 1; u1 = 1; end
                5'b11000: begin c[8] = 1; f = 3; u1 = 1; u2 = 1; b = (f3 == 2) || (f3 == 3); end
                5'b00011: c[9] = 1;
                5'b11100: c[10] = 1;
                default: b = 1;
            endcase
        end
        if ((ud && w[11]) || (u1 && w[19]) || (u2 && w[24])) b = 1'b1;
        return {b, f, a, c};
    endfunction

    // Apply one word, sample after settle, compare every output
    task automatic check(input logic [31:0] w, input string req);
        logic [18:0] e;
        bit bad = 0;
        @(negedge clk);
        instr = w;
        #1;
        e = model(w);
        checks++;
        if (cls !== e[10:0]) begin bad = 1;
            $display("FAIL %s cls w=%h actual=%b expected=%b", req, w, cls, e[10:0]); end
        if (ill !== e[18]) begin bad = 1;
            $display("FAIL %s illegal w=%h actual=%b expected=%b", req, w, ill, e[18]); end
        if (fmt !== e[17:15]) begin bad = 1;
            $display("FAIL %s fmt w=%h actual=%0d expected=%0d", req, w, fmt, e[17:15]); end
        if (!e[18] && alu !== e[14:11]) begin bad = 1;
            $display("FAIL %s alu w=%h actual=%0d expected=%0d", req, w, alu, e[14:11]); end
        if (rd !== w[10:7] || rs1 !== w[18:15] || rs2 !== w[23:20]) begin bad = 1;
            $display("FAIL %s regs w=%h actual=%h/%h/%h expected=%h/%h/%h", req, w,
                     rd, rs1, rs2, w[10:7], w[18:15], w[23:20]); end
        if (bad) errors++;
    endtask

    task automatic t_reset_word();
        // R2: all-zero word is LOAD x0 with legal fields
        check(32'h0000_0003, "R2 reset-word");
    endtask

    task automatic t_quad();
        // R1
        check(32'h0000_0000, "R1 quad00");
        check(enc(7'd0, 5'd1, 5'd2, 3'd0, 5'd3, 5'b01100) & ~32'h1, "R1 quad10");
        check(enc(7'd0, 5'd1, 5'd2, 3'd0, 5'd3, 5'b01100) & ~32'h2, "R1 quad01");
    endtask

    task automatic t_classes();
        // R2 every mapped opcode and some unmapped ones
        logic [4:0] ops [11] = '{5'b00000, 5'b01000, 5'b01100, 5'b00100, 5'b01101,
                                 5'b00101, 5'b11011, 5'b11001, 5'b11000, 5'b00011, 5'b11100};
        foreach (ops[i]) check(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd4, ops[i]), "R2 class");
        check(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd4, 5'b10100), "R2 unmapped");
        check(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd4, 5'b11111), "R2 unmapped");
    endtask

    task automatic t_regs();
        // R3 indices, R4 range rule on used and unused fields
        check(enc(7'd0, 5'd15, 5'd9, 3'd0, 5'd6, 5'b01100), "R3 regs");
        check(enc(7'd0, 5'd16, 5'd1, 3'd0, 5'd2, 5'b01100), "R4 rs2 high");
        check(enc(7'd0, 5'd1, 5'd20, 3'd0, 5'd2, 5'b00100), "R4 rs1 high");
        check(enc(7'd0, 5'd1, 5'd1, 3'd0, 5'd31, 5'b01101), "R4 rd high LUI");
        check(enc(7'd0, 5'd1, 5'd1, 3'd2, 5'd17, 5'b01000), "R4 STORE rd unused");
        check(enc(7'd0, 5'd31, 5'd1, 3'd0, 5'd2, 5'b00100), "R4 OP-IMM rs2 unused");
        check(enc(7'd0, 5'd31, 5'd31, 3'd0, 5'd31, 5'b11100), "R4 SYSTEM unused");
    endtask

    task automatic t_op();
        // R5
        for (int f = 0; f < 8; f++) check(enc(7'd0, 5'd3, 5'd2, 3'(f), 5'd1, 5'b01100), "R5 base");
        check(enc(7'b0100000, 5'd3, 5'd2, 3'd0, 5'd1, 5'b01100), "R5 SUB");
        check(enc(7'b0100000, 5'd3, 5'd2, 3'd5, 5'd1, 5'b01100), "R5 SRA");
    endtask

    task automatic t_czero();
        // R6
        check(enc(7'b0000111, 5'd3, 5'd2, 3'd5, 5'd1, 5'b01100), "R6 eqz");
        check(enc(7'b0000111, 5'd3, 5'd2, 3'd7, 5'd1, 5'b01100), "R6 nez");
    endtask

    task automatic t_opimm();
        // R7
        for (int f = 0; f < 8; f++) check(enc(7'd0, 5'd5, 5'd2, 3'(f), 5'd1, 5'b00100), "R7 imm");
        check(enc(7'b0100000, 5'd5, 5'd2, 3'd5, 5'd1, 5'b00100), "R7 SRAI");
        check(enc(7'b1111111, 5'd5, 5'd2, 3'd0, 5'd1, 5'b00100), "R7 ADDI neg");
    endtask

    task automatic t_bad_funct();
        // R8
        check(enc(7'b0100000, 5'd3, 5'd2, 3'd1, 5'd1, 5'b01100), "R8 OP alt");
        check(enc(7'b0000111, 5'd3, 5'd2, 3'd0, 5'd1, 5'b01100), "R8 OP czero f3");
        check(enc(7'b0000001, 5'd3, 5'd2, 3'd0, 5'd1, 5'b01100), "R8 OP f7");
        check(enc(7'b0100000, 5'd3, 5'd2, 3'd1, 5'd1, 5'b00100), "R8 SLLI f7");
        check(enc(7'b0000001, 5'd3, 5'd2, 3'd5, 5'd1, 5'b00100), "R8 SRxI f7");
    endtask

    task automatic t_mem_branch();
        // R9, with R11 ADD select on legal words
        for (int f = 0; f < 8; f++) begin
            check(enc(7'd0, 5'd3, 5'd2, 3'(f), 5'd1, 5'b00000), "R9 LOAD");
            check(enc(7'd0, 5'd3, 5'd2, 3'(f), 5'd1, 5'b01000), "R9 STORE");
            check(enc(7'd0, 5'd3, 5'd2, 3'(f), 5'd1, 5'b11000), "R9 BRANCH");
        end
    endtask

    task automatic t_fmt_alu();
        // R10 formats, R11 ADD for non-arith classes
        check(enc(7'h55, 5'd3, 5'd2, 3'd0, 5'd1, 5'b11001), "R10 R11 JALR");
        check(enc(7'h55, 5'd3, 5'd2, 3'd7, 5'd1, 5'b11011), "R10 R11 JAL");
        check(enc(7'h55, 5'd3, 5'd2, 3'd7, 5'd1, 5'b00101), "R10 R11 AUIPC");
        check(enc(7'h0, 5'd3, 5'd2, 3'd0, 5'd1, 5'b00011), "R10 R11 MISC-MEM");
    endtask

    task automatic t_sweep();
        // R2 pseudo-random words against the model
        logic [31:0] s = 32'h1234_5679;
        for (int i = 0; i < 3000; i++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            check((i % 2 == 0) ? (s | 32'h3) : s, "R2 sweep");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_word();
        t_quad();
        t_classes();
        t_regs();
        t_op();
        t_czero();
        t_opimm();
        t_bad_funct();
        t_mem_branch();
        t_fmt_alu();
        t_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule